// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog. A free-running counter counts clock cycles while the watchdog is armed, and wraps to zero every 2^W cycles, with W read from an interval register. Expiry has two stages. The first wrap after a kick sets a pending flag and pulses an interrupt. Software can then still recover. A second wrap with the flag still set emits a single-cycle reset request and records the cause in a sticky flag. The system reset generator resets the block in response to that request, and the sticky flag survives that reset.

Arming takes two separate enable keys, each in its own register, so one stray write cannot start or stop the watchdog. Software services the watchdog by writing one to the pending flag. This clears the flag and restarts the counter. A build-time option locks the keys once both are set, so that only a reset can disarm the watchdog. The register port is a plain valid/write/address/data interface. Reads are combinational and have no side effects.

Top module: `wdog_twostage`

## Requirements
- R1: Four 32-bit registers are decoded from byte address bits [3:2]. 0x0 is CTRL0 = {28'b0, cause[3], pending[2], key_a[1], key_b mirror[0]}. 0x4 is CTRL1 = {31'b0, key_b[0]}. 0x8 is the counter value. 0xC is the interval width. After reset, CTRL0, CTRL1 and the counter read 0 and the width reads MAX_WIDTH.
- R2: The counter advances by one per clock only while key_a and key_b are both 1. While either key is 0, the counter reads 0 from the following cycle on.
- R3: With width W, the counter wraps to 0 after 2^W armed cycles. A wrap while pending is 0 sets pending and drives irq high for exactly one cycle.
- R4: A wrap while pending is 1 drives rst_req high for exactly one cycle and sets cause in the same cycle. Starting from an armed counter at 0, this happens 2^(W+1) cycles after arming.
- R5: Writing CTRL0 with bit 2 set (a kick) clears pending and zeroes the counter. Writing bit 2 as 0 leaves pending unchanged. A kick in the same cycle as a wrap wins: no irq and no rst_req follow.
- R6: cause is cleared only by por_rst_n or by writing 1 to CTRL0 bit 3. It keeps its value through sys_rst_n, which clears every other register.
- R7: A width write below 8 stores 8, a write above MAX_WIDTH stores MAX_WIDTH, and any other value is stored as written. A read returns the stored value.
- R8: The counter register is read-only. A write to it changes neither the counter nor any other register.
- R9: With ENABLE_ONCE = 1, once both keys are 1, writes of 0 to either key are ignored. Before both are set, keys can still be cleared.
- R10: CTRL0 bit 0 mirrors key_b. Writes to CTRL0 bit 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, clears all but the cause flag |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for req_addr (combinational) |
| irq | output | 1 | One-cycle first-stage expiry interrupt |
| rst_req | output | 1 | One-cycle second-stage reset request |

## Verification
The assertions assume that a width change does not arrive while the counter is above the new wrap point, and that each reset input is already synchronous to clk. The stimulus changes the width only while the counter is stopped or near zero, and drives every input on the falling edge. The assertions also take the two-stage ordering from the registered irq and rst_req pulses. This holds only because W is at least 8, so two wraps can never fall on adjacent cycles. The random width writes and kick delays are drawn so that the random part never violates these assumptions.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [1:0] SLOT_CTRL0 = 2'd0;
  localparam logic [1:0] SLOT_CTRL1 = 2'd1;
  localparam logic [1:0] SLOT_COUNT = 2'd2;
  localparam logic [1:0] SLOT_WIDTH = 2'd3;

  localparam int unsigned BIT_KEYB_MIRROR = 0;
  localparam int unsigned BIT_KEYA        = 1;
  localparam int unsigned BIT_PENDING     = 2;
  localparam int unsigned BIT_CAUSE       = 3;

  localparam int unsigned MIN_WIDTH = 8;

  // Saturate a requested width into [lo, hi].
  function automatic logic [31:0] clamp_width(input logic [31:0] v,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (v < lo)      return 32'(lo);
    else if (v > hi) return 32'(hi);
    else             return v;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned MAX_WIDTH   = 16,
  parameter bit          ENABLE_ONCE = 1'b0,
  localparam int unsigned WID_W      = $clog2(MAX_WIDTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [3:0]           req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [MAX_WIDTH-1:0] cnt,
  input  logic                 pending,
  input  logic                 cause,
  output logic [31:0]          rdata,
  output logic                 key_a,
  output logic                 key_b,
  output logic [WID_W-1:0]     width,
  output logic                 kick,
  output logic                 cause_clr
);
  logic [1:0]       slot;
  logic             unused_addr_lsbs;
  logic             wr_ctrl0, wr_ctrl1, wr_width;
  logic             locked;
  logic             key_a_nxt, key_b_nxt;
  logic [WID_W-1:0] width_nxt;
  logic [31:0]      width_clamped;

  assign slot             = req_addr[3:2];
  assign unused_addr_lsbs = ^req_addr[1:0];

  assign wr_ctrl0 = req_valid && req_write && (slot == SLOT_CTRL0);
  assign wr_ctrl1 = req_valid && req_write && (slot == SLOT_CTRL1);
  assign wr_width = req_valid && req_write && (slot == SLOT_WIDTH);

  assign locked        = ENABLE_ONCE && key_a && key_b;
  assign width_clamped = clamp_width(req_wdata, MIN_WIDTH, MAX_WIDTH);

  assign kick      = wr_ctrl0 && req_wdata[BIT_PENDING];
  assign cause_clr = wr_ctrl0 && req_wdata[BIT_CAUSE];

  always_comb begin
    key_a_nxt = key_a;
    key_b_nxt = key_b;
    width_nxt = width;
    if (wr_ctrl0) key_a_nxt = req_wdata[BIT_KEYA] | locked;
    if (wr_ctrl1) key_b_nxt = req_wdata[0] | locked;
    if (wr_width) width_nxt = width_clamped[WID_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_a <= 1'b0;
      key_b <= 1'b0;
      width <= WID_W'(MAX_WIDTH);
    end else begin
      key_a <= key_a_nxt;
      key_b <= key_b_nxt;
      width <= width_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (slot)
      SLOT_CTRL0: begin
        rdata[BIT_CAUSE]       = cause;
        rdata[BIT_PENDING]     = pending;
        rdata[BIT_KEYA]        = key_a;
        rdata[BIT_KEYB_MIRROR] = key_b;
      end
      SLOT_CTRL1: rdata[0] = key_b;
      SLOT_COUNT: rdata = 32'(cnt);
      SLOT_WIDTH: rdata = 32'(width);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int unsigned MAX_WIDTH = 16,
  localparam int unsigned WID_W    = $clog2(MAX_WIDTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 kick,
  input  logic [WID_W-1:0]     width,
  output logic [MAX_WIDTH-1:0] cnt,
  output logic                 wrap
);
  logic [MAX_WIDTH-1:0] mask;
  logic [MAX_WIDTH-1:0] cnt_nxt;

  // Low W bits set: the wrap point is 2^W - 1.
  always_comb begin
    for (int i = 0; i < int'(MAX_WIDTH); i++) begin
      mask[i] = (i < int'(width));
    end
  end

  assign wrap = run && ((cnt & mask) == mask);

  always_comb begin
    if (!run || kick || wrap) cnt_nxt = '0;
    else                      cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry (
  input  logic clk,
  input  logic rst_n,
  input  logic por_rst_n,
  input  logic wrap,
  input  logic kick,
  input  logic cause_clr,
  output logic pending,
  output logic irq,
  output logic rst_req,
  output logic cause
);
  logic pending_nxt, irq_nxt, rst_req_nxt, cause_nxt;
  logic live_wrap;

  assign live_wrap = wrap && !kick;

  always_comb begin
    pending_nxt = pending;
    if (kick)      pending_nxt = 1'b0;
    else if (wrap) pending_nxt = 1'b1;
    irq_nxt     = live_wrap && !pending;
    rst_req_nxt = live_wrap && pending;
    cause_nxt   = cause;
    if (rst_req_nxt)    cause_nxt = 1'b1;
    else if (cause_clr) cause_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      pending <= pending_nxt;
      irq     <= irq_nxt;
      rst_req <= rst_req_nxt;
    end
  end

  // Cause flag lives on the power-on reset only.
  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) cause <= 1'b0;
    else            cause <= cause_nxt;
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int unsigned MAX_WIDTH   = 16,
  parameter bit          ENABLE_ONCE = 1'b0
) (
  input  logic        clk,
  input  logic        por_rst_n,
  input  logic        sys_rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam int unsigned WID_W = $clog2(MAX_WIDTH + 1);

  logic                 rst_n_int;
  logic                 key_a, key_b, run;
  logic                 kick, cause_clr, wrap;
  logic                 pending, cause;
  logic [WID_W-1:0]     width;
  logic [MAX_WIDTH-1:0] cnt;

  // Both inputs are assumed synchronised to clk on release upstream.
  assign rst_n_int = por_rst_n & sys_rst_n;
  assign run       = key_a & key_b;

  wdog_regs #(.MAX_WIDTH(MAX_WIDTH), .ENABLE_ONCE(ENABLE_ONCE)) u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cnt(cnt), .pending(pending), .cause(cause),
    .rdata(rsp_rdata), .key_a(key_a), .key_b(key_b),
    .width(width), .kick(kick), .cause_clr(cause_clr)
  );

  wdog_timebase #(.MAX_WIDTH(MAX_WIDTH)) u_timebase (
    .clk(clk), .rst_n(rst_n_int), .run(run), .kick(kick),
    .width(width), .cnt(cnt), .wrap(wrap)
  );

  wdog_expiry u_expiry (
    .clk(clk), .rst_n(rst_n_int), .por_rst_n(por_rst_n),
    .wrap(wrap), .kick(kick), .cause_clr(cause_clr),
    .pending(pending), .irq(irq), .rst_req(rst_req), .cause(cause)
  );
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int unsigned MAX_WIDTH = 16,
  localparam int unsigned WID_W    = $clog2(MAX_WIDTH + 1)
) (
  input logic                 clk,
  input logic                 por_rst_n,
  input logic                 rst_n_int,
  input logic                 run,
  input logic                 kick,
  input logic                 pending,
  input logic                 cause,
  input logic                 irq,
  input logic                 rst_req,
  input logic [WID_W-1:0]     width,
  input logic [MAX_WIDTH-1:0] cnt
);
  a_r2_idle_counter_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    !run |=> (cnt == '0));

  a_r3_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq |=> !irq);

  a_r3_irq_sets_pending: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq |-> pending);

  a_r4_reset_needs_pending: assert property (@(posedge clk) disable iff (!rst_n_int)
    rst_req |-> $past(pending));

  a_r4_reset_single_cycle: assert property (@(posedge clk) disable iff (!rst_n_int)
    rst_req |=> !rst_req);

  a_r6_cause_on_reset_req: assert property (@(posedge clk) disable iff (!por_rst_n)
    rst_req |-> cause);

  a_r5_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n_int)
    kick |=> (!pending && cnt == '0 && !irq && !rst_req));

  a_r7_width_legal: assert property (@(posedge clk) disable iff (!rst_n_int)
    (width >= WID_W'(8)) && (width <= WID_W'(MAX_WIDTH)));
endmodule

bind wdog_twostage wdog_twostage_chk #(.MAX_WIDTH(MAX_WIDTH)) u_chk (
  .clk(clk), .por_rst_n(por_rst_n), .rst_n_int(rst_n_int), .run(run),
  .kick(kick), .pending(pending), .cause(cause), .irq(irq),
  .rst_req(rst_req), .width(width), .cnt(cnt)
);

// File: tb/wdog_twostage_bench.sv
module wdog_twostage_bench;
  localparam int unsigned MAXW = 16;
  localparam int unsigned P    = 256;  // 2^8 with width 8

  logic        clk = 1'b0;
  logic        por_rst_n, sys_rst_n;
  logic        valid_a, valid_b, req_write;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rdata_a, rdata_b, rd_val;
  logic        irq_a, rst_a, irq_b, rst_b;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  wdog_twostage #(.MAX_WIDTH(MAXW), .ENABLE_ONCE(1'b0)) u_wdog_twostage (
    .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
    .req_valid(valid_a), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rdata_a), .irq(irq_a), .rst_req(rst_a));

  wdog_twostage #(.MAX_WIDTH(MAXW), .ENABLE_ONCE(1'b1)) u_wdog_twostage_lock (
    .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
    .req_valid(valid_b), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rdata_b), .irq(irq_b), .rst_req(rst_b));

  function automatic logic [31:0] exp_width(input logic [31:0] v);
    if (v < 8)    return 32'd8;
    if (v > MAXW) return 32'(MAXW);
    return v;
  endfunction

  function automatic logic [31:0] exp_ctrl0(input bit cause, input bit pend,
                                            input bit ka, input bit kb);
    return {28'b0, cause, pend, ka, kb};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [3:0] a, input logic [31:0] d);
    valid_a = !sel; valid_b = sel; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    valid_a = 1'b0; valid_b = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input bit sel, input logic [3:0] a);
    req_addr = a;
    #1;
    rd_val = sel ? rdata_b : rdata_a;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    por_rst_n = 1'b0; sys_rst_n = 1'b1;
    valid_a = 1'b0; valid_b = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    step(3);
    por_rst_n = 1'b1;
    step(1);

    // R1 reset values
    rd(0, 4'h0); check("R1 ctrl0 reset", rd_val, 32'h0);
    rd(0, 4'h4); check("R1 ctrl1 reset", rd_val, 32'h0);
    rd(0, 4'h8); check("R1 count reset", rd_val, 32'h0);
    rd(0, 4'hC); check("R1 width reset", rd_val, 32'(MAXW));

    // R7 clamping: directed corners then random values
    wr(0, 4'hC, 32'd3);   rd(0, 4'hC); check("R7 below min", rd_val, 32'd8);
    wr(0, 4'hC, 32'd200); rd(0, 4'hC); check("R7 above max", rd_val, 32'(MAXW));
    wr(0, 4'hC, 32'd12);  rd(0, 4'hC); check("R7 in range", rd_val, 32'd12);
    for (int i = 0; i < 12; i++) begin
      logic [31:0] v;
      v = (i % 2 == 0) ? ($urandom % 24) : $urandom;
      wr(0, 4'hC, v); rd(0, 4'hC); check("R7 random", rd_val, exp_width(v));
    end
    wr(0, 4'hC, 32'd8);

    // R2 one key only: counter held
    wr(0, 4'h0, 32'h2);
    step(3);
    rd(0, 4'h8); check("R2 one key idle", rd_val, 32'd0);
    wr(0, 4'h4, 32'h1);   // armed; counter 0 now
    step(5);
    rd(0, 4'h8); check("R2 counting", rd_val, 32'd5);
    rd(0, 4'h0); check("R10 mirror", rd_val, exp_ctrl0(0, 0, 1, 1));
    wr(0, 4'h8, 32'hFFFF);
    rd(0, 4'h8); check("R8 count write ignored", rd_val, 32'd6);
    rd(0, 4'hC); check("R8 width untouched", rd_val, 32'd8);
    wr(0, 4'h0, 32'h2);   // bit0 written 0
    rd(0, 4'h0); check("R10 bit0 write ignored", rd_val, exp_ctrl0(0, 0, 1, 1));
    step(P - 1 - 7);
    check("R3 no irq before wrap", {31'b0, irq_a}, 32'd0);
    step(1);
    check("R3 irq at wrap", {31'b0, irq_a}, 32'd1);
    rd(0, 4'h0); check("R3 pending set", rd_val, exp_ctrl0(0, 1, 1, 1));
    step(1);
    check("R3 irq one cycle", {31'b0, irq_a}, 32'd0);
    wr(0, 4'h0, 32'h2);   // pending bit written 0
    rd(0, 4'h0); check("R5 zero write no effect", rd_val, exp_ctrl0(0, 1, 1, 1));
    step(P - 3);
    check("R4 no reset early", {31'b0, rst_a}, 32'd0);
    step(1);
    check("R4 reset request", {31'b0, rst_a}, 32'd1);
    rd(0, 4'h0); check("R4 cause set", rd_val, exp_ctrl0(1, 1, 1, 1));
    step(1);
    check("R4 reset one cycle", {31'b0, rst_a}, 32'd0);

    // R6 system reset keeps cause
    sys_rst_n = 1'b0; step(2); sys_rst_n = 1'b1; step(1);
    rd(0, 4'h0); check("R6 cause survives", rd_val, exp_ctrl0(1, 0, 0, 0));
    rd(0, 4'hC); check("R6 width reset", rd_val, 32'(MAXW));
    wr(0, 4'h0, 32'h8);
    rd(0, 4'h0); check("R6 cause cleared", rd_val, 32'h0);

    // R5 random kick timing
    wr(0, 4'hC, 32'd8);
    wr(0, 4'h0, 32'h2);
    wr(0, 4'h4, 32'h1);
    for (int i = 0; i < 6; i++) begin
      int n;
      n = 1 + int'($urandom % 250);
      step(n);
      rd(0, 4'h8); check("R5 count before kick", rd_val, 32'(n));
      wr(0, 4'h0, 32'h6);
      rd(0, 4'h8); check("R5 kick zeroes count", rd_val, 32'd0);
    end
    // R5 kick on the wrap edge
    step(P - 1);
    wr(0, 4'h0, 32'h6);
    rd(0, 4'h0); check("R5 kick beats wrap", rd_val, exp_ctrl0(0, 0, 1, 1));
    check("R5 no irq on kick wrap", {31'b0, irq_a}, 32'd0);
    step(P);
    rd(0, 4'h0); check("R5 pending after wrap", rd_val, exp_ctrl0(0, 1, 1, 1));
    wr(0, 4'h0, 32'h6);
    step(P - 1);
    rd(0, 4'h0); check("R5 kick cleared pending", rd_val, exp_ctrl0(0, 0, 1, 1));
    step(1);
    check("R5 first stage again", {31'b0, irq_a}, 32'd1);
    check("R5 no reset after kick", {31'b0, rst_a}, 32'd0);

    // R2 disarm
    wr(0, 4'h4, 32'h0);
    step(10);
    rd(0, 4'h8); check("R2 disarmed count", rd_val, 32'd0);
    rd(0, 4'h0); check("R2 disarmed ctrl0", rd_val, exp_ctrl0(0, 1, 1, 0));

    // R9 enable-once lock instance
    wr(1, 4'h0, 32'h2);
    wr(1, 4'h0, 32'h0);
    rd(1, 4'h0); check("R9 clear before lock", rd_val, 32'h0);
    wr(1, 4'h0, 32'h2);
    wr(1, 4'h4, 32'h1);
    wr(1, 4'h4, 32'h0);
    wr(1, 4'h0, 32'h0);
    rd(1, 4'h0); check("R9 locked ctrl0", rd_val, exp_ctrl0(0, 0, 1, 1));
    rd(1, 4'h4); check("R9 locked ctrl1", rd_val, 32'h1);
    rd(1, 4'h8); check("R9 still counting", rd_val, 32'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule